// File: doc/BRIEF.md
# Bus Read Prefetch Controller

This block decides, for a bridge's parallel bus target port, how many cachelines to fetch upstream ahead of an external master's burst read. It also decides when a burst has gone on long enough to be cut. When a read starts, it loads a request window sized by the policy for that command type. As each cacheline begins to move to the master, it can top up the window again. Requests are sent upstream one cacheline address per accepted valid/ready beat. A request goes out only while both a response buffer and an upstream command buffer are free and the address is inside the permitted memory range.

The block counts cachelines in every burst, read or write, and raises a disconnect once a programmable limit is reached. It also tracks how many prefetched lines are held, and drops them all when a scaled discard timer runs out. A 32-bit control register holds the timer value, the burst limit and three prefetch policies. The bus protocol engine, the data buffers and the upstream link are outside the block and are seen only through pulses and status inputs.

Top module: `rd_prefetch_ctl`

## Requirements
- R1: The control register resets to 0x0000_0185. A write stores only bits 15:12 (timer value), 10:9 (burst limit) and 8:0 (three policies), and all other bits read as zero. Policies sit at bits 2:0 for plain memory read, 5:3 for read line and 8:6 for read multiple. Each policy has a top bit that enables continuous prefetch and a 2-bit count, where count c means c+1 cachelines. A register write takes effect from the next cycle.
- R2: `txn_cmd` is encoded as 00 write, 01 memory read, 10 read line and 11 read multiple. A new, non-retried read issues exactly c+1 upstream requests for the count c of its command type. A write issues none.
- R3: A transaction started with `txn_retry` high issues no initial requests.
- R4: With continuous prefetch on, each `line_xfer` of a read first lowers the lines-ahead count by one. It then requests min(3, window − lines ahead) more lines, where the window is c+1. The number of unissued requests never exceeds the lines-ahead count. With continuous prefetch off, `line_xfer` adds no requests.
- R5: `pf_valid` is high only if a request is pending, `resp_buf_free` and `cmd_buf_free` are both high, and either `pf_addr` ≤ `top_of_mem` or `allow_all` is high.
- R6: `pf_addr` equals `txn_addr` after a start and advances by 64 on every accepted request.
- R7: With limit code L (bits 10:9) not zero, `disconnect` is high while the cachelines counted in the current transaction are at least 4·L, and it stays high even when data is ready. L = 0 never disconnects. Reads and writes both count, and pending requests are not cancelled.
- R8: The burst count clears on every `txn_start`, including one that follows a disconnect.
- R9: While lines are held, `discard` pulses after (V+1)·64 cycles, where V is the timer value. Held lines then drop to zero on the next edge.
- R10: The timer restarts when a held line is consumed by `line_xfer`, and it is idle while nothing is held. `line_arrive` adds one held line, saturating at 15.
- R11: If `discard` coincides with `line_arrive` or a consuming `line_xfer`, the discard wins and the held count becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| top_of_mem | input | 32 | Highest address that may be prefetched |
| allow_all | input | 1 | Prefetch regardless of address |
| resp_buf_free | input | 1 | At least one response buffer free |
| cmd_buf_free | input | 1 | At least one upstream command buffer free |
| txn_start | input | 1 | New transaction pulse |
| txn_cmd | input | 2 | Command type of the new transaction |
| txn_retry | input | 1 | Transaction re-issued after a disconnect |
| txn_addr | input | 32 | Start address of the transaction |
| line_xfer | input | 1 | A cacheline starts to move to or from the master |
| line_arrive | input | 1 | A prefetched line became valid |
| pf_valid | output | 1 | Upstream request valid |
| pf_ready | input | 1 | Upstream request accepted |
| pf_addr | output | 32 | Cacheline address of the request |
| disconnect | output | 1 | Burst limit reached, target disconnect |
| discard | output | 1 | Discard timer expired, held data dropped |
| pf_held | output | 4 | Prefetched lines currently held |

## Verification
Two pairs of functions can fire in the same cycle. A timer expiry can meet a line transfer or a line arrival, and a burst-limit disconnect can fall in the cycle where held data is being discarded. The bench fills the limit with a write burst, lets one held line age until `discard` is seen, and then drives `line_xfer` and `line_arrive` into that very cycle. It judges that `disconnect` stays high and that the held count ends at zero. A long random phase then lets these events and the policy top-ups collide freely, while a behavioural model checks every output on every clock.

// File: rtl/rd_prefetch_ctl.sv
module rd_prefetch_ctl #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int TMR_UNIT   = 64,
  parameter int CNT_W      = 5,
  parameter int HELD_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [AW-1:0]     top_of_mem,
  input  logic              allow_all,
  input  logic              resp_buf_free,
  input  logic              cmd_buf_free,
  input  logic              txn_start,
  input  logic [1:0]        txn_cmd,
  input  logic              txn_retry,
  input  logic [AW-1:0]     txn_addr,
  input  logic              line_xfer,
  input  logic              line_arrive,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [AW-1:0]     pf_addr,
  output logic              disconnect,
  output logic              discard,
  output logic [HELD_W-1:0] pf_held
);
  localparam logic [31:0] CFG_RST  = 32'h0000_0185;
  localparam logic [31:0] CFG_MASK = 32'h0000_F7FF;
  localparam int TMR_W = $clog2(16 * TMR_UNIT);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [HELD_W:0]   HELD_MAX = {1'b0, {HELD_W{1'b1}}};

  logic [31:0]       cfg;
  logic              rd_act, cpf;
  logic [2:0]        win, pend, ahead;
  logic [CNT_W-1:0]  bcnt;
  logic [HELD_W-1:0] held;
  logic [TMR_W-1:0]  tmr;
  logic [2:0]        pol;

  always_comb begin
    case (txn_cmd)
      2'd1:    pol = cfg[2:0];
      2'd2:    pol = cfg[5:3];
      2'd3:    pol = cfg[8:6];
      default: pol = 3'd0;
    endcase
  end

  wire [2:0] pol_win = {1'b0, pol[1:0]} + 3'd1;
  wire       is_rd   = (txn_cmd != 2'd0);

  assign cfg_rdata = cfg;
  assign pf_held   = held;
  assign pf_valid  = (pend != 3'd0) && resp_buf_free && cmd_buf_free &&
                     (allow_all || (pf_addr <= top_of_mem));
  wire accept  = pf_valid && pf_ready;
  wire trig    = line_xfer && rd_act && cpf;
  wire consume = line_xfer && (held != '0);

  wire [2:0] ahead_dec = (ahead == 3'd0) ? 3'd0 : ahead - 3'd1;
  wire [2:0] gap       = (win > ahead_dec) ? win - ahead_dec : 3'd0;
  wire [2:0] add       = (gap > 3'd3) ? 3'd3 : gap;
  wire [2:0] ahead_nx  = ahead_dec + add;
  wire [2:0] pend_sum  = pend - {2'b00, accept} + add;
  wire [2:0] pend_cap  = (pend_sum > ahead_nx) ? ahead_nx : pend_sum;

  wire [CNT_W-1:0] blimit = CNT_W'({cfg[10:9], 2'b00});
  assign disconnect = (cfg[10:9] != 2'b00) && (bcnt >= blimit);

  wire [TMR_W-1:0] tmr_lim = TMR_W'((32'(cfg[15:12]) + 32'd1) * TMR_UNIT - 32'd1);
  assign discard = (held != '0) && (tmr >= tmr_lim);

  wire [HELD_W:0] held_sum = {1'b0, held} + {{HELD_W{1'b0}}, line_arrive}
                             - {{HELD_W{1'b0}}, consume};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= CFG_RST;
    else if (cfg_we) cfg <= cfg_wdata & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act  <= 1'b0;
      cpf     <= 1'b0;
      win     <= 3'd1;
      pend    <= 3'd0;
      ahead   <= 3'd0;
      pf_addr <= '0;
      bcnt    <= '0;
    end else if (txn_start) begin
      rd_act  <= is_rd;
      cpf     <= pol[2];
      win     <= pol_win;
      pend    <= (is_rd && !txn_retry) ? pol_win : 3'd0;
      ahead   <= (is_rd && !txn_retry) ? pol_win : 3'd0;
      pf_addr <= txn_addr;
      bcnt    <= '0;
    end else begin
      if (trig) begin
        ahead <= ahead_nx;
        pend  <= pend_cap;
      end else begin
        pend  <= pend - {2'b00, accept};
      end
      if (accept) pf_addr <= pf_addr + AW'(LINE_BYTES);
      if (line_xfer && bcnt != CNT_MAX) bcnt <= bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      tmr  <= '0;
    end else if (discard) begin
      held <= '0;
      tmr  <= '0;
    end else begin
      held <= (held_sum > HELD_MAX) ? HELD_MAX[HELD_W-1:0] : held_sum[HELD_W-1:0];
      tmr  <= (consume || held == '0) ? '0 : tmr + 1'b1;
    end
  end
endmodule

// File: rtl/rd_prefetch_ctl_chk.sv
module rd_prefetch_ctl_chk #(
  parameter int AW = 32, LINE_BYTES = 64, HELD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg_rdata,
  input logic [AW-1:0]     top_of_mem,
  input logic              allow_all,
  input logic              resp_buf_free,
  input logic              cmd_buf_free,
  input logic              txn_start,
  input logic [1:0]        txn_cmd,
  input logic              txn_retry,
  input logic              line_xfer,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [AW-1:0]     pf_addr,
  input logic              disconnect,
  input logic              discard,
  input logic [HELD_W-1:0] pf_held
);
  assert_cfg_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:16] == 16'd0 && !cfg_rdata[11]);
  assert_write_no_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start && txn_cmd == 2'd0 |=> !pf_valid);
  assert_retry_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start && txn_retry |=> !pf_valid);
  assert_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> resp_buf_free && cmd_buf_free && (allow_all || pf_addr <= top_of_mem));
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && !txn_start |=> pf_addr == $past(pf_addr) + AW'(LINE_BYTES));
  assert_unlimited_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[10:9] == 2'b00 |-> !disconnect);
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |=> !disconnect);
  assert_discard_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> pf_held == '0);
  assert_consume_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    line_xfer && pf_held > 4'd1 && !discard |=> !discard);
endmodule

bind rd_prefetch_ctl rd_prefetch_ctl_chk #(.AW(AW), .LINE_BYTES(LINE_BYTES), .HELD_W(HELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .top_of_mem(top_of_mem),
  .allow_all(allow_all), .resp_buf_free(resp_buf_free), .cmd_buf_free(cmd_buf_free),
  .txn_start(txn_start), .txn_cmd(txn_cmd), .txn_retry(txn_retry), .line_xfer(line_xfer),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .disconnect(disconnect),
  .discard(discard), .pf_held(pf_held));

// File: tb/rd_prefetch_ctl_tb_top.sv
`timescale 1ns/1ps
module rd_prefetch_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, allow_all = 0, resp_buf_free = 1, cmd_buf_free = 1;
  logic txn_start = 0, txn_retry = 0, line_xfer = 0, line_arrive = 0, pf_ready = 1;
  logic [1:0] txn_cmd = 0;
  logic [31:0] cfg_wdata = 0, top_of_mem = 32'h8000_0000, txn_addr = 0;
  logic [31:0] cfg_rdata, pf_addr;
  logic pf_valid, disconnect, discard;
  logic [3:0] pf_held;

  int nchk = 0, nfail = 0, acc_cnt = 0;

  always #2 clk = ~clk;

  rd_prefetch_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .top_of_mem(top_of_mem), .allow_all(allow_all), .resp_buf_free(resp_buf_free),
    .cmd_buf_free(cmd_buf_free), .txn_start(txn_start), .txn_cmd(txn_cmd),
    .txn_retry(txn_retry), .txn_addr(txn_addr), .line_xfer(line_xfer),
    .line_arrive(line_arrive), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
    .disconnect(disconnect), .discard(discard), .pf_held(pf_held));

  // behavioural reference state
  logic [31:0] m_cfg = 32'h185, m_addr = 0;
  int m_rd = 0, m_cpf = 0, m_win = 1, m_pend = 0, m_ahead = 0, m_bcnt = 0, m_held = 0, m_tmr = 0;

  function automatic int policy(logic [1:0] cmd);
    case (cmd)
      2'd1: return int'(m_cfg[2:0]);
      2'd2: return int'(m_cfg[5:3]);
      2'd3: return int'(m_cfg[8:6]);
      default: return 0;
    endcase
  endfunction
  function automatic bit m_valid();
    return m_pend > 0 && resp_buf_free && cmd_buf_free && (allow_all || m_addr <= top_of_mem);
  endfunction
  function automatic bit m_discard();
    return m_held > 0 && m_tmr >= (int'(m_cfg[15:12]) + 1) * 64 - 1;
  endfunction
  function automatic bit m_disc();
    int lim = int'(m_cfg[10:9]) * 4;
    return lim != 0 && m_bcnt >= lim;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 32'h185; m_addr = 0; m_rd = 0; m_cpf = 0; m_win = 1; m_pend = 0;
      m_ahead = 0; m_bcnt = 0; m_held = 0; m_tmr = 0;
    end else begin
      bit acc, cons, dsc;
      int pol, ad, gap, add, np, nh;
      acc  = m_valid() && pf_ready;
      cons = line_xfer && m_held > 0;
      dsc  = m_discard();
      if (dsc) begin m_held = 0; m_tmr = 0; end
      else begin
        nh = m_held + (line_arrive ? 1 : 0) - (cons ? 1 : 0);
        if (nh > 15) nh = 15;
        if (cons || m_held == 0) m_tmr = 0; else m_tmr = m_tmr + 1;
        m_held = nh;
      end
      if (txn_start) begin
        pol = policy(txn_cmd);
        m_rd = (txn_cmd != 0);
        m_cpf = (pol >> 2) & 1;
        m_win = (pol & 3) + 1;
        m_pend = (m_rd != 0 && !txn_retry) ? m_win : 0;
        m_ahead = m_pend;
        m_addr = txn_addr;
        m_bcnt = 0;
      end else begin
        np = m_pend - (acc ? 1 : 0);
        if (line_xfer && m_rd != 0 && m_cpf != 0) begin
          ad = (m_ahead > 0) ? m_ahead - 1 : 0;
          gap = (m_win > ad) ? m_win - ad : 0;
          add = (gap > 3) ? 3 : gap;
          m_ahead = ad + add;
          np = np + add;
          if (np > m_ahead) np = m_ahead;
        end
        m_pend = np;
        if (acc) m_addr = m_addr + 64;
        if (line_xfer && m_bcnt < 31) m_bcnt = m_bcnt + 1;
      end
      if (cfg_we) m_cfg = cfg_wdata & 32'h0000_F7FF;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 cfg_rdata", cfg_rdata, m_cfg);
      chk("R5 pf_valid", {31'd0, pf_valid}, {31'd0, m_valid()});
      chk("R6 pf_addr", pf_addr, m_addr);
      chk("R7 disconnect", {31'd0, disconnect}, {31'd0, m_disc()});
      chk("R9 discard", {31'd0, discard}, {31'd0, m_discard()});
      chk("R10 pf_held", {28'd0, pf_held}, m_held[31:0]);
      if (pf_valid && pf_ready) acc_cnt++;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) tick(); endtask
  task automatic wr_cfg(logic [31:0] v);
    cfg_we = 1; cfg_wdata = v; tick(); cfg_we = 0;
  endtask
  task automatic start(logic [1:0] cmd, logic rty, logic [31:0] a);
    txn_start = 1; txn_cmd = cmd; txn_retry = rty; txn_addr = a; tick();
    txn_start = 0; txn_retry = 0;
  endtask
  task automatic xfer(); line_xfer = 1; tick(); line_xfer = 0; endtask

  initial begin
    #(4 * 150000);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int base;
    idle(3); rst_n = 1; #1;
    tick();
    chk("R1 reset value", cfg_rdata, 32'h0000_0185);
    chk("R1 reset idle", {29'd0, pf_valid, disconnect, discard}, 32'd0);
    wr_cfg(32'hFFFF_FFFF);
    chk("R1 reserved bits", cfg_rdata, 32'h0000_F7FF);
    wr_cfg(32'h0000_0185);

    // R2: memory read, count 01 -> 2 lines
    base = acc_cnt; start(2'd1, 0, 32'h1000); idle(6);
    chk("R2 read initial count", acc_cnt - base, 2);
    // R2: write issues nothing
    base = acc_cnt; start(2'd0, 0, 32'h2000); idle(4);
    chk("R2 write no fetch", acc_cnt - base, 0);
    // R4 disabled: read line, 1 line, no top-up
    base = acc_cnt; start(2'd2, 0, 32'h3000); idle(3); xfer(); idle(2); xfer(); idle(3);
    chk("R4 continuous off", acc_cnt - base, 1);
    // R4 enabled: read multiple, 3 lines, +1 per transfer
    base = acc_cnt; start(2'd3, 0, 32'h4000); idle(5); xfer(); idle(3); xfer(); idle(3);
    chk("R4 top-up", acc_cnt - base, 5);
    // R3 retry, then R4 cap of three with window 4
    wr_cfg(32'h0000_0187);
    base = acc_cnt; start(2'd1, 1, 32'h5000); idle(4);
    chk("R3 retry no initial", acc_cnt - base, 0);
    xfer(); idle(5);
    chk("R4 at most three", acc_cnt - base, 3);
    // R5 gating
    resp_buf_free = 0;
    base = acc_cnt; start(2'd1, 0, 32'h6000); idle(4);
    chk("R5 response buffer full", acc_cnt - base, 0);
    resp_buf_free = 1; idle(6);
    chk("R5 released", acc_cnt - base, 4);
    base = acc_cnt; start(2'd1, 0, 32'h9000_0000); idle(4);
    chk("R5 above top of memory", acc_cnt - base, 0);
    allow_all = 1; idle(6); allow_all = 0;
    chk("R5 allow all", acc_cnt - base, 4);
    chk("R6 address after four", pf_addr, 32'h9000_0100);

    // R9/R10 timer, V=0 then V=1
    line_arrive = 1; idle(2); line_arrive = 0; idle(70);
    chk("R9 discard after 64", {28'd0, pf_held}, 32'd0);
    wr_cfg(32'h0000_1185);
    line_arrive = 1; idle(2); line_arrive = 0; idle(100);
    xfer(); idle(100);
    chk("R10 restart on consume", {28'd0, pf_held}, 32'd1);
    idle(40);
    chk("R9 discard after 128", {28'd0, pf_held}, 32'd0);

    // R7 limit 4 on a write burst, then coincidence with discard (R11)
    wr_cfg(32'h0000_0385);
    start(2'd0, 0, 32'h7000);
    for (int i = 0; i < 3; i++) xfer();
    chk("R7 below limit", {31'd0, disconnect}, 32'd0);
    xfer();
    chk("R7 at limit", {31'd0, disconnect}, 32'd1);
    line_arrive = 1; tick(); line_arrive = 0;
    for (int i = 0; i < 100 && !discard; i++) tick();
    chk("R11 discard seen", {31'd0, discard}, 32'd1);
    chk("R7 disconnect with discard", {31'd0, disconnect}, 32'd1);
    line_xfer = 1; line_arrive = 1; tick(); line_xfer = 0; line_arrive = 0;
    chk("R11 discard wins", {28'd0, pf_held}, 32'd0);
    start(2'd1, 1, 32'h7100);
    chk("R8 cleared on start", {31'd0, disconnect}, 32'd0);

    // random phase, model compared every cycle
    for (int c = 0; c < 4000; c++) begin
      txn_start     = ($urandom % 20) == 0;
      txn_cmd       = 2'($urandom);
      txn_retry     = ($urandom % 4) == 0;
      txn_addr      = $urandom & 32'hFFFF_FFC0;
      line_xfer     = ($urandom % 3) == 0;
      line_arrive   = ($urandom % 4) == 0;
      pf_ready      = ($urandom % 2) == 0;
      resp_buf_free = ($urandom % 4) != 0;
      cmd_buf_free  = ($urandom % 4) != 0;
      allow_all     = ($urandom % 8) == 0;
      cfg_we        = ($urandom % 200) == 0;
      cfg_wdata     = $urandom & 32'hFFFF_37FF;
      tick();
    end
    cfg_we = 0; txn_start = 0; line_xfer = 0; line_arrive = 0;
    idle(2);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule